// File: doc/BRIEF.md
# Successive-Approximation Converter Controller with Parallel Read Port

This block is the digital half of a 12-bit successive-approximation converter that hangs off a processor bus. Five asynchronous control pins are brought into the clock domain: a chip enable, an active-low chip select, a read/convert select, a full-width/byte format select and an address select. A conversion starts when the combined term (enable high, select low, read/convert low) becomes true. It does not matter which of the three pins completes the combination. The address select is captured at that moment and decides whether the conversion resolves all 12 bits or stops after the top 8.

While a conversion runs, a busy flag is high. The sequencer presents a trial code to an external DAC and reads back a single comparator bit, one result bit per clock. Start requests that arrive during a conversion are dropped. The result can be read when read/convert is high, busy is low, enable is high and select is low. It is then driven either as one 12-bit word or as one of two byte lanes on the upper eight data pins. In place of tri-state pads the block provides a data output-enable. The read port is level-gated, so it has no valid/ready pair and no back-pressure: the data stays on the pins for as long as the four read conditions hold.

Top module: `sar_adc_ctrl`

## Requirements
- R1: During reset and just after it, busy_o, data_oe_o and data_o are all zero.
- R2: Every control input passes through a two-flop synchronizer. A conversion starts on the rising edge of the synchronized term (ce_i=1, cs_n_i=0, rc_i=0), whichever input completes it. busy_o rises at the third clock edge after the last input settles.
- R3: addr_sel_i is sampled at the start event. A value of 0 gives a 12-bit conversion with busy_o high for 13 cycles. A value of 1 gives an 8-bit conversion with busy_o high for 9 cycles. Changing addr_sel_i during a conversion does not change its length.
- R4: The sequencer resolves bits from MSB to LSB, and dac_code_o carries the trial code. cmp_i=1 keeps the trial bit and cmp_i=0 clears it. A 12-bit result therefore equals the largest code for which the comparator reports 1.
- R5: A rising edge of the start term while busy_o is high neither restarts nor lengthens the conversion. If the term is still high when busy_o falls, no new conversion starts.
- R6: data_oe_o is 1 exactly when the synchronized rc_i=1, ce_i=1, cs_n_i=0 and busy_o=0. While data_oe_o is 0, data_o is all zero.
- R7: With the synchronized fmt12_i=1 and the read enabled, data_o[11:0] carries the full stored result.
- R8: With fmt12_i=0 and the read enabled, data_o[3:0] is zero. data_o[11:4] carries result[11:4] when addr_sel_i=0, and {result[3:0],4'b0000} when addr_sel_i=1. This uses the live synchronized address, not the captured one.
- R9: An 8-bit conversion stores result[3:0] as 4'b1000, so a full-width read returns a one on bit 3 and zeros on bits 2 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Chip enable, active high, asynchronous |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| rc_i | input | 1 | 0 requests a conversion, 1 requests a read |
| fmt12_i | input | 1 | 1 = full-width read, 0 = byte-lane read |
| addr_sel_i | input | 1 | Sets conversion length at start; selects the byte lane on reads |
| cmp_i | input | 1 | Comparator: 1 when the analog input is at or above the trial code |
| busy_o | output | 1 | High while a conversion is in progress |
| dac_code_o | output | 12 | Trial code for the external DAC |
| data_o | output | 12 | Read data, zero when not enabled |
| data_oe_o | output | 1 | Enable for the external data bus drivers |

## Verification
The hardest case to reach from the pins is a second start edge that arrives in the middle of a conversion. The bench creates it by raising read/convert and lowering it again while busy is high, and keeps the term high past the end of the conversion. A stray restart would show up as a longer busy window or as a late restart. The mid-conversion change of the address select is exercised the same way during an 8-bit conversion. The comparator is modelled from the trial code against a fixed threshold. Threshold values of zero and all ones test both ends of the bit search.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_RESOLVE = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int NBITS      = 12,
  parameter int SHORT_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             short_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic [NBITS-1:0] code_o,
  output logic [NBITS-1:0] result_o
);
  localparam int IDXW = $clog2(NBITS);
  localparam int PADW = NBITS - SHORT_BITS;
  localparam logic [NBITS-1:0] ONE      = {{(NBITS-1){1'b0}}, 1'b1};
  localparam logic [NBITS-1:0] MSB_ONE  = {1'b1, {(NBITS-1){1'b0}}};
  localparam logic [NBITS-1:0] LOW_MASK = (ONE << PADW) - ONE;
  localparam logic [NBITS-1:0] PAD      = ONE << (PADW - 1);
  localparam logic [IDXW-1:0]  STOP_SHORT = IDXW'(PADW);
  localparam logic [IDXW-1:0]  STOP_FULL  = '0;

  sar_state_e       state;
  logic             req_q;
  logic             short_q;
  logic [IDXW-1:0]  idx;
  logic [NBITS-1:0] code_q, res_q;
  logic [NBITS-1:0] keep_mask, trial, code_next, res_next;
  logic [IDXW-1:0]  stop_idx;
  logic             at_stop, start;

  assign start    = req_i && !req_q && (state == ST_IDLE);
  assign stop_idx = short_q ? STOP_SHORT : STOP_FULL;
  assign at_stop  = (idx == stop_idx);

  always_comb begin
    keep_mask = ONE << idx;
    trial     = cmp_i ? code_q : (code_q & ~keep_mask);
    code_next = at_stop ? trial : (trial | (keep_mask >> 1));
    res_next  = short_q ? ((trial & ~LOW_MASK) | PAD) : trial;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      req_q   <= 1'b0;
      short_q <= 1'b0;
      idx     <= '0;
      code_q  <= '0;
      res_q   <= '0;
    end else begin
      req_q <= req_i;
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_SETUP;
          short_q <= short_i;
          code_q  <= '0;
        end
        ST_SETUP: begin
          code_q <= MSB_ONE;
          idx    <= IDXW'(NBITS - 1);
          state  <= ST_RESOLVE;
        end
        ST_RESOLVE: begin
          code_q <= code_next;
          if (at_stop) begin
            res_q <= res_next;
            state <= ST_IDLE;
          end else begin
            idx <= idx - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state != ST_IDLE);
  assign code_o   = code_q;
  assign result_o = res_q;

  // R5: a fresh request edge while converting must not send the sequencer back to setup
  assert_ignore_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && req_i && !req_q) |=> (state != ST_SETUP));

  // R3: captured length stays fixed for the whole conversion
  assert_hold_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(short_q));

  // R4: the first trial after setup is the MSB alone
  assert_msb_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SETUP) |=> (code_o == MSB_ONE));

  // R9: a short conversion ends with the padding pattern in the low bits
  assert_short_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && short_q) |-> ((result_o & LOW_MASK) == PAD));
endmodule

// File: rtl/sar_bus.sv
module sar_bus #(
  parameter int NBITS = 12,
  parameter int LANE  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_i,
  input  logic             busy_i,
  input  logic             ce_i,
  input  logic             cs_n_i,
  input  logic             full_i,
  input  logic             addr_i,
  input  logic [NBITS-1:0] result_i,
  output logic [NBITS-1:0] data_o,
  output logic             oe_o
);
  localparam int NIB = NBITS - LANE;

  logic [NBITS-1:0] lane_hi, lane_lo;

  assign lane_hi = {result_i[NBITS-1:NIB], {NIB{1'b0}}};
  assign lane_lo = {result_i[NIB-1:0], {(NBITS-NIB){1'b0}}};
  assign oe_o    = rd_i && !busy_i && ce_i && !cs_n_i;

  always_comb begin
    if (!oe_o)       data_o = '0;
    else if (full_i) data_o = result_i;
    else if (addr_i) data_o = lane_lo;
    else             data_o = lane_hi;
  end

  // R6: the bus stays quiet whenever it is not enabled
  assert_quiet_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_o |-> (data_o == '0));

  // R8: byte reads never drive the low nibble
  assert_lane_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o && !full_i) |-> (data_o[NIB-1:0] == '0));
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int NBITS      = 12,
  parameter int SHORT_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_i,
  input  logic             cs_n_i,
  input  logic             rc_i,
  input  logic             fmt12_i,
  input  logic             addr_sel_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic [NBITS-1:0] dac_code_o,
  output logic [NBITS-1:0] data_o,
  output logic             data_oe_o
);
  localparam int NCTL = 5;

  logic [NCTL-1:0]  ctl_s;
  logic             ce_s, cs_n_s, rc_s, fmt_s, addr_s, req;
  logic [NBITS-1:0] result;

  sar_sync #(.W(NCTL)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ce_i, cs_n_i, rc_i, fmt12_i, addr_sel_i}),
    .q    (ctl_s)
  );

  assign {ce_s, cs_n_s, rc_s, fmt_s, addr_s} = ctl_s;
  assign req = ce_s && !cs_n_s && !rc_s;

  sar_seq #(.NBITS(NBITS), .SHORT_BITS(SHORT_BITS)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req),
    .short_i (addr_s),
    .cmp_i   (cmp_i),
    .busy_o  (busy_o),
    .code_o  (dac_code_o),
    .result_o(result)
  );

  sar_bus #(.NBITS(NBITS), .LANE(SHORT_BITS)) u_bus (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_i    (rc_s),
    .busy_i  (busy_o),
    .ce_i    (ce_s),
    .cs_n_i  (cs_n_s),
    .full_i  (fmt_s),
    .addr_i  (addr_s),
    .result_i(result),
    .data_o  (data_o),
    .oe_o    (data_oe_o)
  );

  // R6: data is never offered while a conversion runs
  assert_no_drive_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_o |-> !busy_o);

  // R5: busy never drops and returns in consecutive cycles because of a re-request
  assert_no_retrigger_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |=> !busy_o);
endmodule

// File: tb/tb_sar_adc_ctrl.sv
module tb_sar_adc_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0, cs_n = 1'b1, rc = 1'b1, fmt = 1'b1, addr = 1'b0;
  logic [11:0] vin = 12'h000;
  logic        cmp;
  logic        busy, oe;
  logic [11:0] dac, data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign cmp = (dac <= vin);

  sar_adc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .cs_n_i(cs_n), .rc_i(rc),
    .fmt12_i(fmt), .addr_sel_i(addr), .cmp_i(cmp),
    .busy_o(busy), .dac_code_o(dac), .data_o(data), .data_oe_o(oe)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %h expected %h", tag, what, $time, act, exp);
    end
  endtask

  // behavioural reference: sync history, busy countdown, stored result
  int          m_cnt = 0;
  logic [11:0] m_res = '0;
  logic        m_short = 1'b0, m_reqp = 1'b0;
  logic [4:0]  s1 = '0, s2 = '0;

  always @(posedge clk) begin
    logic req, e_busy, e_oe;
    logic [11:0] e_data;
    string dtag;
    if (!rst_n) begin
      m_cnt = 0; m_res = '0; m_short = 1'b0; m_reqp = 1'b0; s1 = '0; s2 = '0;
    end else begin
      req = s2[4] && !s2[3] && !s2[2];
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) m_res = m_short ? {vin[11:4], 4'b1000} : vin;
      end else if (req && !m_reqp) begin
        m_short = s2[0];
        m_cnt   = s2[0] ? 9 : 13;
      end
      m_reqp = req;
      s2 = s1;
      s1 = {ce, cs_n, rc, fmt, addr};
    end
    #3;
    e_busy = (m_cnt > 0);
    e_oe   = s2[2] && !e_busy && s2[4] && !s2[3];
    if (!e_oe)      e_data = '0;
    else if (s2[1]) e_data = m_res;
    else if (s2[0]) e_data = {m_res[3:0], 8'h00};
    else            e_data = {m_res[11:4], 4'h0};
    dtag = !rst_n ? "R1" : (!e_oe ? "R6" : (!s2[1] ? "R8" : (m_short ? "R9" : "R4 R7")));
    check(busy === e_busy, !rst_n ? "R1" : "R2 R3 R5", "busy", {11'd0, busy}, {11'd0, e_busy});
    check(oe === e_oe, !rst_n ? "R1" : "R6", "oe", {11'd0, oe}, {11'd0, e_oe});
    check(data === e_data, dtag, "data", data, e_data);
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);

    // R2 R4 R7 R8: 12-bit conversion, chip select completes the term
    vin = 12'hA5C; ce = 1'b1; rc = 1'b0;
    wait_n(4);
    cs_n = 1'b0;
    wait_n(20);
    rc = 1'b1;
    wait_n(6);
    fmt = 1'b0; addr = 1'b0;
    wait_n(4);
    addr = 1'b1;
    wait_n(4);
    cs_n = 1'b1;          // R6: select released, bus goes quiet
    wait_n(4);

    // R3 R9: 8-bit conversion, read/convert completes the term, address flips mid-way
    vin = 12'h3C7; fmt = 1'b1; addr = 1'b1; cs_n = 1'b0; ce = 1'b1;
    wait_n(4);
    rc = 1'b0;
    wait_n(5);
    addr = 1'b0;
    wait_n(15);
    rc = 1'b1;
    wait_n(6);
    fmt = 1'b0;
    wait_n(3);
    addr = 1'b1;
    wait_n(3);
    fmt = 1'b1;
    wait_n(3);

    // R5: enable completes the term, then a second request edge during busy
    vin = 12'hFFF; ce = 1'b0; addr = 1'b0; rc = 1'b0; cs_n = 1'b0;
    wait_n(4);
    ce = 1'b1;
    wait_n(6);
    rc = 1'b1;
    wait_n(2);
    rc = 1'b0;
    wait_n(20);
    rc = 1'b1;
    wait_n(5);

    // R4: zero input, read/convert last again
    vin = 12'h000;
    rc = 1'b0;
    wait_n(20);
    rc = 1'b1;
    wait_n(5);
    ce = 1'b0;            // R6: enable dropped
    wait_n(4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule